// File: doc/BRIEF.md
# SAR ADC Conversion Control Unit

This block holds the digital sequencing and register state for a 10-bit successive-approximation analog-to-digital converter run one channel at a time. Software programs a control/status register over a simple strobe-based register bus: it chooses an input channel, enables the interrupt, and sets a start bit. A conversion can also be launched by a rising edge on an external trigger pin. While converting, the block drives a trial code to an external DAC and reads back one comparator decision per cycle. It resolves one bit per cycle, from the most significant bit down.

When the last bit is decided, the result goes into one of four read-only result registers, the done flag rises and the start bit drops, all on the same clock edge. The interrupt line is high while the done flag and the interrupt enable are both set. Clearing the done flag takes a handshake: software must first read the control register and see the flag at 1, and then write 0 to it. The analog comparator, the DAC and the input multiplexer sit outside the block.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is 0, `dacCode` is 0 and `chanSel` is 0. The control register is at address 0 with start at bit 0, done at bit 1, interrupt enable at bit 2, mode at bit 3 and the 3-bit channel at bits 6:4. All other bits and unmapped addresses read 0.
- R2: Writing 1 to the start bit while idle begins a conversion. The start bit then reads 1 for exactly 11 cycles (10 approximation cycles plus 1 store cycle) and returns to 0 by itself.
- R3: A rising edge on `extTrig` while idle starts a conversion on the channel currently held in the control register.
- R4: During approximation cycle k (k = 0..9), `dacCode` shows the bits already decided, plus a trial 1 at bit 9-k. That trial bit is kept when `cmpHigh` is 1 (input at or above the code). The stored result therefore equals the input code. Outside the approximation cycles `dacCode` is 0.
- R5: On the store edge, the result is written to the result register at address 4 + chan[1:0], the done flag is set, and the start bit clears, all on that one edge.
- R6: `irq` is 1 exactly when the done flag and the interrupt enable are both 1.
- R7: A write of 0 to the done bit clears it only if the control register was earlier read with done = 1. Without that read, the flag stays set. Writing 1 to the done bit never sets it.
- R8: Writing 0 to the start bit during a conversion halts it. No result register changes and the done flag keeps its value.
- R9: A write that sets the start bit and at the same time changes the channel and mode starts a conversion that uses the new channel.
- R10: While a conversion runs, trigger edges and writes of 1 to the start bit have no effect on it. Later changes to the channel field do not redirect where the result is stored.
- R11: `chanSel` shows the channel latched when the current or most recent conversion started. The channel code is plain binary. Its two low bits pick the result register, so 010 stores at address 6 and 110 also stores at address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (arms the done-flag clear) |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed register (combinational) |
| extTrig | input | 1 | External conversion trigger, rising-edge sensitive |
| cmpHigh | input | 1 | Comparator: analog input is at or above `dacCode` |
| dacCode | output | 10 | Trial code to the external DAC |
| chanSel | output | 3 | Analog multiplexer channel select |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
The approximation is driven with input codes 0, 1023, 511, 512, 677 and a few others. The extremes show whether any trial bit is wrongly kept or dropped. The 511/512 pair separates an error at the MSB decision from one in the lower bits, and because the DAC trial code is compared on every cycle, an error in bit order or in the compare sense is caught in the cycle where it happens. Conversions are started both by software write and by trigger edge. Some conversions are disturbed by an abort write, an extra trigger or a rewrite of the start bit. Others use channel codes whose high bit differs, which separates store-address errors from multiplexer errors. The done-flag handshake is tried with and without the arming read.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  // Control register field positions
  localparam int BIT_START = 0;
  localparam int BIT_DONE  = 1;
  localparam int BIT_IE    = 2;
  localparam int BIT_MODE  = 3;
  localparam int CHAN_LSB  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_STORE = 2'd2
  } convState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startConv;  // load MSB trial code
    logic convPhase;  // one approximation step this cycle
    logic storeRes;   // commit result to a result register
  } dpCmd_t;

endpackage

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
#(
  parameter int CHAN_W = 3,
  parameter int ADDR_W = 3,
  localparam int CTRL_W = CHAN_LSB + CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              extTrig,
  input  logic              lastBit,
  output dpCmd_t            dpCmd,
  output logic [CHAN_W-1:0] convChan,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              armed,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  convState_t        stQ, stD;
  logic              trigQ, doneQ, ieQ, modeQ, armedQ;
  logic [CHAN_W-1:0] chanQ, convChanQ;
  logic              wrCtrl, rdCtrl, trigRise, busy;
  logic              startReq, abortReq, storeNow;

  assign wrCtrl   = busWrEn && (busAddr == CTRL_ADDR);
  assign rdCtrl   = busRdEn && (busAddr == CTRL_ADDR);
  assign trigRise = extTrig && !trigQ;
  assign busy     = (stQ != ST_IDLE);

  assign startReq = !busy && ((wrCtrl && wrData[BIT_START]) || trigRise);
  assign abortReq = busy && wrCtrl && !wrData[BIT_START];
  assign storeNow = (stQ == ST_STORE) && !abortReq;

  always_comb begin
    stD = stQ;
    unique case (stQ)
      ST_IDLE:  if (startReq) stD = ST_CONV;
      ST_CONV:  if (abortReq) stD = ST_IDLE;
                else if (lastBit) stD = ST_STORE;
      ST_STORE: stD = ST_IDLE;
      default:  stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ       <= ST_IDLE;
      trigQ     <= 1'b0;
      doneQ     <= 1'b0;
      ieQ       <= 1'b0;
      modeQ     <= 1'b0;
      armedQ    <= 1'b0;
      chanQ     <= '0;
      convChanQ <= '0;
    end else begin
      stQ   <= stD;
      trigQ <= extTrig;
      if (startReq)
        convChanQ <= wrCtrl ? wrData[CHAN_LSB +: CHAN_W] : chanQ;
      if (wrCtrl) begin
        ieQ   <= wrData[BIT_IE];
        modeQ <= wrData[BIT_MODE];
        chanQ <= wrData[CHAN_LSB +: CHAN_W];
      end
      if (storeNow) begin
        doneQ  <= 1'b1;
        armedQ <= 1'b0;
      end else if (wrCtrl && !wrData[BIT_DONE] && armedQ) begin
        doneQ  <= 1'b0;
        armedQ <= 1'b0;
      end else if (rdCtrl && doneQ) begin
        armedQ <= 1'b1;
      end
    end
  end

  assign dpCmd.startConv = startReq;
  assign dpCmd.convPhase = (stQ == ST_CONV);
  assign dpCmd.storeRes  = storeNow;

  assign convChan = convChanQ;
  assign ctrlWord = {chanQ, modeQ, ieQ, doneQ, busy};
  assign armed    = armedQ;
  assign irq      = doneQ && ieQ;

endmodule

// File: rtl/adc_sar_dpath.sv
module adc_sar_dpath
  import adc_sar_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int NUM_RES = 4,
  localparam int IDX_W  = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpCmd_t                          dpCmd,
  input  logic [IDX_W-1:0]                storeIdx,
  input  logic                            cmpHigh,
  output logic [RES_W-1:0]                dacCode,
  output logic                            lastBit,
  output logic [NUM_RES-1:0][RES_W-1:0]   results
);

  localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sarQ, maskQ, sarNext;

  // Decide the current trial bit and place the next trial bit below it
  always_comb begin
    sarNext = sarQ;
    if (!cmpHigh) sarNext = sarNext & ~maskQ;
    sarNext = sarNext | (maskQ >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ  <= '0;
      maskQ <= '0;
    end else if (dpCmd.startConv) begin
      sarQ  <= MSB_MASK;
      maskQ <= MSB_MASK;
    end else if (dpCmd.convPhase) begin
      sarQ  <= sarNext;
      maskQ <= maskQ >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      results <= '0;
    end else if (dpCmd.storeRes) begin
      for (int i = 0; i < NUM_RES; i++)
        if (storeIdx == IDX_W'(i)) results[i] <= sarQ;
    end
  end

  assign lastBit = maskQ[0];
  assign dacCode = dpCmd.convPhase ? sarQ : '0;

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_sar_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CHAN_W  = 3,
  parameter int NUM_RES = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              extTrig,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  dacCode,
  output logic [CHAN_W-1:0] chanSel,
  output logic              irq
);

  localparam int CTRL_W = CHAN_LSB + CHAN_W;
  localparam int IDX_W  = (NUM_RES > 1) ? $clog2(NUM_RES) : 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  dpCmd_t                        dpCmd;
  logic [CHAN_W-1:0]             convChan;
  logic [CTRL_W-1:0]             ctrlWord;
  logic                          ctrlArmed, lastBit;
  logic [NUM_RES-1:0][RES_W-1:0] results;
  logic                          unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:CTRL_W];

  adc_sar_ctrl #(.CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .wrData   (busWdata[CTRL_W-1:0]),
    .extTrig  (extTrig),
    .lastBit  (lastBit),
    .dpCmd    (dpCmd),
    .convChan (convChan),
    .ctrlWord (ctrlWord),
    .armed    (ctrlArmed),
    .irq      (irq)
  );

  adc_sar_dpath #(.RES_W(RES_W), .NUM_RES(NUM_RES)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .dpCmd    (dpCmd),
    .storeIdx (convChan[IDX_W-1:0]),
    .cmpHigh  (cmpHigh),
    .dacCode  (dacCode),
    .lastBit  (lastBit),
    .results  (results)
  );

  // Control at address 0, result registers in the upper half of the map
  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_ADDR)
      busRdata[CTRL_W-1:0] = ctrlWord;
    else if (busAddr[ADDR_W-1])
      busRdata[RES_W-1:0] = results[busAddr[IDX_W-1:0]];
  end

  assign chanSel = convChan;

endmodule

// File: rtl/adc_sar_chk.sv
module adc_sar_chk #(
  parameter int RES_W  = 10,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startBit,
  input logic              doneBit,
  input logic              ieBit,
  input logic              armedBit,
  input logic              irq,
  input logic [RES_W-1:0]  dacCode,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wdDone
);

  localparam logic [RES_W-1:0] MSB_CODE = {1'b1, {(RES_W-1){1'b0}}};

  logic [7:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (startBit) busyCnt <= busyCnt + 8'd1;
    else busyCnt <= '0;
  end

  // R2
  start_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    startBit |-> (busyCnt <= 8'(RES_W)));

  // R4
  dac_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startBit) |-> (dacCode == MSB_CODE));

  // R4
  dac_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |-> (dacCode == '0));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneBit) |-> $fell(startBit));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneBit) |-> $past(busWrEn && (busAddr == '0) && !wdDone && armedBit));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ieBit |-> !irq);

endmodule

bind adc_sar_seq adc_sar_chk #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startBit (ctrlWord[adc_sar_pkg::BIT_START]),
  .doneBit  (ctrlWord[adc_sar_pkg::BIT_DONE]),
  .ieBit    (ctrlWord[adc_sar_pkg::BIT_IE]),
  .armedBit (ctrlArmed),
  .irq      (irq),
  .dacCode  (dacCode),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .wdDone   (busWdata[adc_sar_pkg::BIT_DONE])
);

// File: tb/tb_adc_sar_seq.sv
`timescale 1ns/1ps
module tb_adc_sar_seq;

  logic        clk = 1'b0;
  logic        rstN, busWrEn, busRdEn, extTrig;
  logic [2:0]  busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic [9:0]  dacCode;
  logic [2:0]  chanSel;
  logic        irq, cmpHigh;
  int          vin;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Analog side: ideal comparator against the DAC code
  assign cmpHigh = (vin >= int'(dacCode));

  adc_sar_seq dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .extTrig(extTrig), .cmpHigh(cmpHigh), .dacCode(dacCode),
    .chanSel(chanSel), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mPhase, mStart, mDone, mIe, mMode, mChan, mLch, mArmed, mTrigQ;
  int mRes[4];

  function automatic int expDac();
    int k;
    if (mPhase < 1 || mPhase > 10) return 0;
    k = mPhase - 1;
    return ((vin >> (10 - k)) << (10 - k)) | (1 << (9 - k));
  endfunction

  function automatic int expRd();
    if (busAddr == 0) return (mChan << 4) | (mMode << 3) | (mIe << 2) | (mDone << 1) | mStart;
    if (busAddr >= 4) return mRes[busAddr - 4];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mStart = 0; mDone = 0; mIe = 0; mMode = 0; mChan = 0;
      mLch = 0; mArmed = 0; mTrigQ = 0;
      foreach (mRes[i]) mRes[i] = 0;
    end else begin
      bit wr, rd, rise, stored;
      wr = busWrEn && busAddr == 0;
      rd = busRdEn && busAddr == 0;
      rise = extTrig && !mTrigQ;
      mTrigQ = extTrig;
      stored = 0;
      if (mPhase > 0) begin
        if (wr && !busWdata[0]) begin mPhase = 0; mStart = 0; end
        else if (mPhase == 11) begin
          mRes[mLch % 4] = vin; stored = 1; mStart = 0; mPhase = 0;
        end else mPhase++;
      end else if ((wr && busWdata[0]) || rise) begin
        mPhase = 1; mStart = 1;
        mLch = wr ? int'(busWdata[6:4]) : mChan;
      end
      if (stored) begin mDone = 1; mArmed = 0; end
      else if (wr && !busWdata[1] && mArmed) begin mDone = 0; mArmed = 0; end
      else if (rd && mDone) mArmed = 1;
      if (wr) begin
        mIe = busWdata[2]; mMode = busWdata[3]; mChan = int'(busWdata[6:4]);
      end
    end
    #1;
    if (rstN) begin
      chk("R6 irq", irq, (mDone && mIe) ? 1 : 0);
      chk("R4 dacCode", dacCode, expDac());
      chk("R2 rdata", busRdata, expRd());
      chk("R11 chanSel", chanSel, mLch);
    end
  end

  task automatic wr(input logic [15:0] d);
    busAddr = 0; busWdata = d; busWrEn = 1;
    @(posedge clk); @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rdc();
    busAddr = 0; busRdEn = 1;
    @(posedge clk); @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic trig();
    extTrig = 1;
    @(posedge clk); @(negedge clk);
    extTrig = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output int v);
    busAddr = a; #1; v = busRdata;
  endtask

  initial begin
    int v;
    rstN = 0; busWrEn = 0; busRdEn = 0; extTrig = 0; busAddr = 0; busWdata = 0; vin = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    peek(0, v); chk("R1 ctrl", v, 0);
    peek(6, v); chk("R1 result", v, 0);
    peek(1, v); chk("R1 unmapped", v, 0);
    chk("R1 irq", irq, 0); chk("R1 dac", dacCode, 0); chk("R1 chanSel", chanSel, 0);

    // R2 R5 R11: software start on channel 010
    vin = 677; wr(16'h25);
    cyc(10); peek(0, v); chk("R2 start held", v & 1, 1);
    cyc(1); peek(0, v); chk("R5 ctrl after store", v, 'h26);
    peek(6, v); chk("R5 R11 result ch2", v, 677);
    chk("R6 irq set", irq, 1);

    // R7 done handshake
    wr(16'h24); peek(0, v); chk("R7 no read no clear", v, 'h26);
    rdc(); wr(16'h24); peek(0, v); chk("R7 cleared", v, 'h24);
    chk("R7 irq low", irq, 0);
    wr(16'h26); peek(0, v); chk("R7 write one ignored", v, 'h24);

    // R3 trigger start, extremes
    vin = 1023; wr(16'h10); trig(); cyc(11);
    peek(5, v); chk("R3 trig result", v, 1023);
    peek(0, v); chk("R3 ctrl", v, 'h12);
    rdc(); wr(16'h10);
    vin = 0; trig(); cyc(11);
    peek(5, v); chk("R4 zero input", v, 0);
    rdc(); wr(16'h10);

    // R4 MSB boundary pair
    vin = 512; wr(16'h01); cyc(11); peek(4, v); chk("R4 512", v, 512);
    vin = 511; wr(16'h31); cyc(11); peek(7, v); chk("R4 511", v, 511);
    rdc(); wr(16'h30);

    // R8 abort
    vin = 300; wr(16'h31); cyc(4); wr(16'h30); cyc(12);
    peek(7, v); chk("R8 result untouched", v, 511);
    peek(0, v); chk("R8 ctrl idle no done", v, 'h30);

    // R9 start with new channel and mode in one write
    vin = 123; wr(16'h49);
    chk("R11 chanSel latched", chanSel, 4);
    cyc(11); peek(4, v); chk("R9 result ch4", v, 123);
    peek(0, v); chk("R9 ctrl", v, 'h4A);
    rdc(); wr(16'h48);

    // R10 trigger and start rewrite during conversion
    vin = 800; wr(16'h21); cyc(2); trig(); cyc(2); wr(16'h05);
    peek(0, v); chk("R10 ctrl mid", v, 'h05);
    cyc(4); peek(0, v); chk("R10 still busy", v & 1, 1);
    cyc(1); peek(6, v); chk("R10 result ch2", v, 800);
    peek(4, v); chk("R10 ch0 untouched", v, 123);
    cyc(15); peek(0, v); chk("R10 no restart", v & 1, 0);

    // R11 channel 110 stores by low bits
    vin = 55; wr(16'h61); cyc(11);
    peek(6, v); chk("R11 ch6 result", v, 55);
    chk("R11 chanSel 6", chanSel, 6);

    // R6 enable gating
    wr(16'h60); chk("R6 irq off", irq, 0);
    wr(16'h64); chk("R6 irq on", irq, 1);

    cyc(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule